// File: doc/BRIEF.md
# DS2 Overhead Alarm and Loopback Monitor

This block watches the overhead bits of one received DS2 stream. A frame aligner upstream supplies the serial data bit, a strobe that marks each valid bit, a pulse that marks the first bit of each M-frame, and a flag that says alignment is lost. From these the block tracks where each bit sits in the M-frame. It then picks out the overhead bits it needs.

The M position of the fourth subframe carries the far-end alarm bit. The block filters that bit so the alarm output changes only when two M-frames in a row agree. In each subframe, the block compares the third C-bit with the first two. A 2-bit code selects which relationship counts as a loopback request, and the result is kept per tributary. Rising and falling request edges set sticky flags, which are cleared by writing ones. The block also counts framing bit errors (F-bits and the fixed M-bits) against the current or last known alignment.

The far-end alarm filter is a four-state machine:
- `FERF_IDLE_OK` is the alarm-off state. A zero alarm bit moves it to `FERF_ZERO_SEEN`.
- From `FERF_ZERO_SEEN`, a second zero moves it to `FERF_ACTIVE` and a one moves it back to `FERF_IDLE_OK`.
- `FERF_ACTIVE` is the alarm-on state. A one moves it to `FERF_ONE_SEEN`.
- From `FERF_ONE_SEEN`, a second one moves it to `FERF_IDLE_OK` and a zero moves it back to `FERF_ACTIVE`.
- All other inputs leave the state unchanged.

Top module: `ds2_oh_alarm_mon`

## Requirements
- R1: A bit is taken only in a cycle with `bit_en` high. A bit taken with `frame_start` high is the first overhead bit of an M-frame. Without `frame_start`, position advances freely through 4 subframes × 6 blocks × 49 bits, where bit 0 of each block is overhead. The overhead order in a subframe is M, C1, F0, C2, C3, F1.
- R2: `ferf` goes to 1 when the alarm bit (the M position of subframe 4) is 0 in two consecutive in-frame M-frames.
- R3: `ferf` goes to 0 when the alarm bit is 1 in two consecutive in-frame M-frames.
- R4: An alarm bit that disagrees with `ferf` only once, followed by an agreeing bit, leaves `ferf` unchanged.
- R5: On the C3 bit of subframe t (0..3), `lb_req[t]` is updated from that subframe's C1, C2 and C3. The code selects the request condition:
  - `lb_code`=0: C3 differs from both C1 and C2.
  - `lb_code`=1: C3 equals both C1 and C2.
  - `lb_code`=2: C3 differs from C1.
  - `lb_code`=3: C3 differs from C2.
- R6: A 0→1 change of `lb_req[t]` sets the sticky flag `set_irq[t]`.
- R7: A 1→0 change of `lb_req[t]` sets the sticky flag `clr_irq[t]`.
- R8: A 1 on `set_ack[t]` or `clr_ack[t]` clears the matching flag on the next edge. A new event in the same cycle as the clear wins, and the flag stays 1.
- R9: While `oof` is high, `ferf`, the alarm filter state and `lb_req` hold, and no flag is set.
- R10: `fm_err_cnt` counts one error per F0 bit not 0, per F1 bit not 1, and per M bit of subframes 1..3 not equal to 0, 1, 1. It counts during `oof` too, and saturates at all ones.
- R11: After reset, `ferf`, `lb_req`, both flag vectors and `fm_err_cnt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Marks a valid received bit on `din` |
| din | input | 1 | Received DS2 data bit |
| frame_start | input | 1 | With `bit_en`, marks the first bit of an M-frame |
| oof | input | 1 | Frame alignment lost; status updates frozen |
| lb_code | input | 2 | Selects the C3 relationship that means a loopback request |
| set_ack | input | 4 | Write-one-to-clear for `set_irq` |
| clr_ack | input | 4 | Write-one-to-clear for `clr_irq` |
| ferf | output | 1 | Filtered far-end receive failure status |
| lb_req | output | 4 | Loopback request status per tributary |
| set_irq | output | 4 | Sticky flag: request appeared |
| clr_irq | output | 4 | Sticky flag: request went away |
| fm_err_cnt | output | ERR_W | Saturating framing-bit error count |

## Verification
The hardest situation to reach from the ports is a flag clear that lands in exactly the cycle of a new request edge. To reach it, the frame generator drives `set_ack` only on the C3 bit of a chosen subframe. A further hard case is a run of alarm bits split across an out-of-frame stretch, which checks that the filter's half-way state survives the stretch. The bench also cuts a frame short and restarts it with `frame_start`, and it inserts random strobe gaps carrying junk data. Saturation is reached by building the block with a narrow counter and sending frames with every F-bit and M-bit inverted.

// File: rtl/ds2_ohm_pkg.sv
package ds2_ohm_pkg;

    localparam int NUM_TRIB       = 4;
    localparam int BLOCKS_PER_SUB = 6;

    // overhead slot order within one subframe; the decode depends on it
    typedef enum logic [2:0] {
        OH_M  = 3'd0,
        OH_C1 = 3'd1,
        OH_F0 = 3'd2,
        OH_C2 = 3'd3,
        OH_C3 = 3'd4,
        OH_F1 = 3'd5
    } oh_role_e;

    typedef enum logic [1:0] {
        FERF_IDLE_OK,
        FERF_ZERO_SEEN,
        FERF_ACTIVE,
        FERF_ONE_SEEN
    } ferf_state_e;

    function automatic logic lb_decode(input logic [1:0] code,
                                       input logic c1, input logic c2,
                                       input logic c3);
        logic d1, d2;
        d1 = c3 ^ c1;
        d2 = c3 ^ c2;
        unique case (code)
            2'd0:    return d1 & d2;
            2'd1:    return ~d1 & ~d2;
            2'd2:    return d1;
            default: return d2;
        endcase
    endfunction

endpackage

// File: rtl/ds2_oh_slot.sv
module ds2_oh_slot
    import ds2_ohm_pkg::*;
#(
    parameter int BLOCK_BITS = 49
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       frame_start,
    output logic       oh_bit,
    output oh_role_e   role,
    output logic [1:0] sub
);
    localparam int BIT_W = $clog2(BLOCK_BITS);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(BLOCK_BITS - 1);
    localparam logic [2:0]       LAST_ROLE = 3'(BLOCKS_PER_SUB - 1);

    logic [BIT_W-1:0] bit_q, bit_n;
    logic [2:0]       role_q, role_n;
    logic [1:0]       sub_q, sub_n;

    always_comb begin
        bit_n  = bit_q;
        role_n = role_q;
        sub_n  = sub_q;
        if (frame_start) begin
            bit_n  = '0;
            role_n = '0;
            sub_n  = '0;
        end else if (bit_q == LAST_BIT) begin
            bit_n = '0;
            if (role_q == LAST_ROLE) begin
                role_n = '0;
                sub_n  = sub_q + 2'd1;
            end else begin
                role_n = role_q + 3'd1;
            end
        end else begin
            bit_n = bit_q + BIT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q  <= LAST_BIT;
            role_q <= LAST_ROLE;
            sub_q  <= 2'd3;
        end else if (bit_en) begin
            bit_q  <= bit_n;
            role_q <= role_n;
            sub_q  <= sub_n;
        end
    end

    assign oh_bit = (bit_n == '0);
    assign role   = oh_role_e'(role_n);
    assign sub    = sub_n;

endmodule

// File: rtl/ds2_ferf_fsm.sv
module ds2_ferf_fsm
    import ds2_ohm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic x_stb,
    input  logic x_bit,
    output logic ferf
);
    ferf_state_e state_q, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FERF_IDLE_OK;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        if (x_stb) begin
            unique case (state_q)
                FERF_IDLE_OK:   state_n = x_bit ? FERF_IDLE_OK  : FERF_ZERO_SEEN;
                FERF_ZERO_SEEN: state_n = x_bit ? FERF_IDLE_OK  : FERF_ACTIVE;
                FERF_ACTIVE:    state_n = x_bit ? FERF_ONE_SEEN : FERF_ACTIVE;
                FERF_ONE_SEEN:  state_n = x_bit ? FERF_IDLE_OK  : FERF_ACTIVE;
                default:        state_n = FERF_IDLE_OK;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            FERF_ACTIVE, FERF_ONE_SEEN: ferf = 1'b1;
            default:                    ferf = 1'b0;
        endcase
    end

endmodule

// File: rtl/ds2_lb_mon.sv
module ds2_lb_mon
    import ds2_ohm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                oh_stb,
    input  logic                oof,
    input  logic                din,
    input  oh_role_e            role,
    input  logic [1:0]          sub,
    input  logic [1:0]          code,
    input  logic [NUM_TRIB-1:0] set_ack,
    input  logic [NUM_TRIB-1:0] clr_ack,
    output logic [NUM_TRIB-1:0] lb_req,
    output logic [NUM_TRIB-1:0] set_irq,
    output logic [NUM_TRIB-1:0] clr_irq
);
    logic c1_q, c2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c1_q <= 1'b0;
            c2_q <= 1'b0;
        end else if (oh_stb) begin
            if (role == OH_C1) c1_q <= din;
            if (role == OH_C2) c2_q <= din;
        end
    end

    for (genvar t = 0; t < NUM_TRIB; t++) begin : g_trib
        logic upd, req_n, rise, fall;

        assign upd   = oh_stb && !oof && (role == OH_C3) && (sub == 2'(t));
        assign req_n = lb_decode(code, c1_q, c2_q, din);
        assign rise  = upd &&  req_n && !lb_req[t];
        assign fall  = upd && !req_n &&  lb_req[t];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lb_req[t]  <= 1'b0;
                set_irq[t] <= 1'b0;
                clr_irq[t] <= 1'b0;
            end else begin
                if (upd) lb_req[t] <= req_n;
                set_irq[t] <= (set_irq[t] && !set_ack[t]) || rise;
                clr_irq[t] <= (clr_irq[t] && !clr_ack[t]) || fall;
            end
        end
    end

endmodule

// File: rtl/ds2_oh_alarm_mon.sv
module ds2_oh_alarm_mon
    import ds2_ohm_pkg::*;
#(
    parameter int BLOCK_BITS = 49,
    parameter int ERR_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             din,
    input  logic             frame_start,
    input  logic             oof,
    input  logic [1:0]       lb_code,
    input  logic [3:0]       set_ack,
    input  logic [3:0]       clr_ack,
    output logic             ferf,
    output logic [3:0]       lb_req,
    output logic [3:0]       set_irq,
    output logic [3:0]       clr_irq,
    output logic [ERR_W-1:0] fm_err_cnt
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    logic       oh_bit, oh_stb, x_stb, bad_bit;
    oh_role_e   role;
    logic [1:0] sub;

    ds2_oh_slot #(.BLOCK_BITS(BLOCK_BITS)) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .frame_start (frame_start),
        .oh_bit      (oh_bit),
        .role        (role),
        .sub         (sub)
    );

    assign oh_stb = bit_en && oh_bit;
    assign x_stb  = oh_stb && !oof && (role == OH_M) && (sub == 2'd3);

    ds2_ferf_fsm u_ferf (
        .clk   (clk),
        .rst_n (rst_n),
        .x_stb (x_stb),
        .x_bit (din),
        .ferf  (ferf)
    );

    ds2_lb_mon u_lb (
        .clk     (clk),
        .rst_n   (rst_n),
        .oh_stb  (oh_stb),
        .oof     (oof),
        .din     (din),
        .role    (role),
        .sub     (sub),
        .code    (lb_code),
        .set_ack (set_ack),
        .clr_ack (clr_ack),
        .lb_req  (lb_req),
        .set_irq (set_irq),
        .clr_irq (clr_irq)
    );

    // framing bit check: F0 = 0, F1 = 1, M of subframes 0..2 = 0,1,1
    always_comb begin
        bad_bit = 1'b0;
        if (oh_stb) begin
            unique case (role)
                OH_F0:   bad_bit = din;
                OH_F1:   bad_bit = !din;
                OH_M:    bad_bit = (sub != 2'd3) && (din != (sub != 2'd0));
                default: bad_bit = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             fm_err_cnt <= '0;
        else if (bad_bit && fm_err_cnt != ERR_MAX) fm_err_cnt <= fm_err_cnt + ERR_W'(1);
    end

endmodule

// File: rtl/ds2_ohm_checker.sv
module ds2_ohm_checker #(
    parameter int ERR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             oof,
    input logic             ferf,
    input logic [3:0]       lb_req,
    input logic [3:0]       set_irq,
    input logic [3:0]       clr_irq,
    input logic [ERR_W-1:0] fm_err_cnt
);
    p_ferf_hold_oof_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oof |=> $stable(ferf));

    p_lb_hold_oof_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oof |=> $stable(lb_req));

    p_ferf_needs_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(ferf));

    p_rise_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 ((lb_req & ~$past(lb_req) & ~set_irq) == 4'd0));

    p_fall_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 ((~lb_req & $past(lb_req) & ~clr_irq) == 4'd0));

    p_err_monotonic_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (fm_err_cnt >= $past(fm_err_cnt)));

endmodule

bind ds2_oh_alarm_mon ds2_ohm_checker #(.ERR_W(ERR_W)) u_ohm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .oof        (oof),
    .ferf       (ferf),
    .lb_req     (lb_req),
    .set_irq    (set_irq),
    .clr_irq    (clr_irq),
    .fm_err_cnt (fm_err_cnt)
);

// File: tb/test_ds2_oh_alarm_mon.sv
module test_ds2_oh_alarm_mon;
    localparam int BB    = 49;
    localparam int FLEN  = BB * 24;
    localparam int ERR_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0, din = 1'b0, frame_start = 1'b0, oof = 1'b0;
    logic [1:0] lb_code = 2'd0;
    logic [3:0] set_ack = 4'd0, clr_ack = 4'd0;
    logic ferf;
    logic [3:0] lb_req, set_irq, clr_irq;
    logic [ERR_W-1:0] fm_err_cnt;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    ds2_oh_alarm_mon #(.BLOCK_BITS(BB), .ERR_W(ERR_W)) i_ds2_oh_alarm_mon (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .din(din),
        .frame_start(frame_start), .oof(oof), .lb_code(lb_code),
        .set_ack(set_ack), .clr_ack(clr_ack), .ferf(ferf), .lb_req(lb_req),
        .set_irq(set_irq), .clr_irq(clr_irq), .fm_err_cnt(fm_err_cnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_pos, m_prev_x, m_c1, m_c2, m_err;
    bit m_ferf;
    bit [3:0] m_req, m_set, m_clr;

    function automatic bit mdec(input int code, input int c1, input int c2, input int c3);
        case (code)
            0:       return (c3 != c1) && (c3 != c2);
            1:       return (c3 == c1) && (c3 == c2);
            2:       return c3 != c1;
            default: return c3 != c2;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = FLEN - 1; m_prev_x = -1; m_c1 = 0; m_c2 = 0; m_err = 0;
            m_ferf = 0; m_req = 0; m_set = 0; m_clr = 0;
        end else begin
            m_set = m_set & ~set_ack;
            m_clr = m_clr & ~clr_ack;
            if (bit_en) begin
                m_pos = frame_start ? 0 : (m_pos + 1) % FLEN;
                if (m_pos % BB == 0) begin
                    int blk, s, r, v;
                    blk = m_pos / BB; s = blk / 6; r = blk % 6; v = din;
                    if (r == 2 && v != 0) m_err++;
                    if (r == 5 && v != 1) m_err++;
                    if (r == 0 && s < 3 && v != (s == 0 ? 0 : 1)) m_err++;
                    if (m_err > 31) m_err = 31;
                    if (r == 1) m_c1 = v;
                    if (r == 3) m_c2 = v;
                    if (!oof) begin
                        if (r == 0 && s == 3) begin
                            if (v == m_prev_x) m_ferf = (v == 0);
                            m_prev_x = v;
                        end
                        if (r == 4) begin
                            bit nr;
                            nr = mdec(lb_code, m_c1, m_c2, v);
                            if (nr && !m_req[s]) m_set[s] = 1'b1;
                            if (!nr && m_req[s]) m_clr[s] = 1'b1;
                            m_req[s] = nr;
                        end
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2/R3 ferf vs model", ferf, m_ferf);
            chk("R5 lb_req vs model", lb_req, m_req);
            chk("R6 set_irq vs model", set_irq, m_set);
            chk("R7 clr_irq vs model", clr_irq, m_clr);
            chk("R10 fm_err_cnt vs model", fm_err_cnt, m_err);
        end
    end

    // ---------------- stimulus ----------------
    task automatic send_frame(input logic x, input logic [11:0] cb, input logic ferr,
                              input logic mflip, input logic oofv, input int nbits,
                              input logic with_fs, input logic [3:0] ack_c3);
        for (int p = 0; p < nbits; p++) begin
            int blk, b, s, r;
            logic v;
            if ($urandom_range(0, 4) == 0) begin
                @(negedge clk);
                bit_en = 0; frame_start = 0; set_ack = 0; din = 1'($urandom);
            end
            blk = p / BB; b = p % BB; s = blk / 6; r = blk % 6;
            v = 1'($urandom);
            if (b == 0) begin
                case (r)
                    0: v = (s == 3) ? x : ((s == 0 ? 1'b0 : 1'b1) ^ mflip);
                    1: v = cb[3*s+2];
                    2: v = 1'b0 ^ ferr;
                    3: v = cb[3*s+1];
                    4: v = cb[3*s];
                    default: v = 1'b1 ^ ferr;
                endcase
            end
            @(negedge clk);
            bit_en = 1; din = v; oof = oofv;
            frame_start = with_fs && (p == 0);
            set_ack = (b == 0 && r == 4) ? (ack_c3 & (4'd1 << s)) : 4'd0;
        end
        @(negedge clk);
        bit_en = 0; frame_start = 0; set_ack = 0; oof = 0;
    endtask

    task automatic frm(input logic x, input logic [11:0] cb);
        send_frame(x, cb, 1'b0, 1'b0, 1'b0, FLEN, 1'b1, 4'd0);
    endtask

    task automatic ack(input logic [3:0] s, input logic [3:0] c);
        @(negedge clk); set_ack = s; clr_ack = c;
        @(negedge clk); set_ack = 0; clr_ack = 0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
        $finish;
    end

    // cb per tributary t at [3t+2:3t] = {C1, C2, C3}
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11 reset ferf", ferf, 0);
        chk("R11 reset lb_req", lb_req, 0);
        chk("R11 reset irqs", {set_irq, clr_irq}, 0);
        chk("R11 reset err", fm_err_cnt, 0);

        lb_code = 2'd0;
        frm(1, 12'o0000);
        frm(0, 12'o0000);
        chk("R4 single zero no change", ferf, 0);
        frm(0, 12'o0000);
        chk("R2 two zeros set ferf", ferf, 1);
        frm(1, 12'o0000);
        chk("R4 single one no change", ferf, 1);
        // trib3 {1,1,1}, trib2 {0,0,1}, trib1 {1,0,0}, trib0 {1,1,0}
        frm(1, 12'o7146);
        chk("R3 two ones clear ferf", ferf, 0);
        chk("R5 code0 requests", lb_req, 4'b0101);
        chk("R6 set flags", set_irq, 4'b0101);
        ack(4'b0001, 4'b0000);
        chk("R8 w1c set flag", set_irq, 4'b0100);
        frm(1, 12'o7140);
        chk("R5 trib0 released", lb_req, 4'b0100);
        chk("R7 clr flag trib0", clr_irq, 4'b0001);

        lb_code = 2'd1;
        // trib3 {1,0,1}, trib2 {0,0,1}, trib1 {1,1,1}, trib0 {0,0,0}
        frm(1, 12'o5170);
        chk("R5 code1 requests", lb_req, 4'b0011);
        chk("R6 set accum", set_irq, 4'b0111);
        chk("R7 clr accum", clr_irq, 4'b0101);
        ack(4'hF, 4'hF);
        chk("R8 w1c all", {set_irq, clr_irq}, 0);

        send_frame(0, 12'o5555, 0, 0, 1, FLEN, 1, 4'd0);
        send_frame(0, 12'o5555, 0, 0, 1, FLEN, 1, 4'd0);
        chk("R9 ferf held in oof", ferf, 0);
        chk("R9 lb_req held in oof", lb_req, 4'b0011);
        chk("R9 no flags in oof", {set_irq, clr_irq}, 0);
        frm(0, 12'o5170);
        chk("R9 filter resumes at one zero", ferf, 0);
        frm(0, 12'o5170);
        chk("R2 set after oof", ferf, 1);

        lb_code = 2'd2;
        // trib3 {0,0,1}, trib2 {1,1,1}, trib1 {1,0,1}, trib0 {0,1,1}
        frm(1, 12'o1753);
        chk("R5 code2 requests", lb_req, 4'b1001);
        lb_code = 2'd3;
        // trib3 {1,1,0}, trib2 {0,0,0}, trib1 {1,0,1}, trib0 {0,1,1}
        frm(1, 12'o6053);
        chk("R5 code3 requests", lb_req, 4'b1010);
        chk("R3 cleared again", ferf, 0);
        ack(4'hF, 4'hF);
        // trib0 {0,0,1} rises while its ack hits the same edge
        send_frame(1, 12'o6001, 0, 0, 0, FLEN, 1, 4'b0001);
        chk("R8 set wins over ack", set_irq, 4'b0001);
        chk("R7 trib1 fell", clr_irq, 4'b0010);

        send_frame(1, 12'o6001, 1, 0, 0, FLEN, 1, 4'd0);
        chk("R10 F errors", fm_err_cnt, 8);
        send_frame(1, 12'o6001, 0, 1, 1, FLEN, 1, 4'd0);
        chk("R10 M errors during oof", fm_err_cnt, 11);
        send_frame(1, 12'o6001, 1, 1, 0, FLEN, 1, 4'd0);
        chk("R10 mixed errors", fm_err_cnt, 22);
        send_frame(1, 12'o6001, 1, 1, 0, FLEN, 1, 4'd0);
        chk("R10 saturates", fm_err_cnt, 31);

        send_frame(1, 12'o6001, 0, 0, 0, 300, 1, 4'd0);
        frm(0, 12'o6001);
        frm(0, 12'o6001);
        chk("R1 realign on frame_start", ferf, 1);
        send_frame(1, 12'o6001, 0, 0, 0, FLEN, 0, 4'd0);
        send_frame(1, 12'o6001, 0, 0, 0, FLEN, 0, 4'd0);
        chk("R1 free-running position", ferf, 0);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule